// File: doc/BRIEF.md
# Unlock-Sequence Special Command Decoder

This block sits between the programming-port protocol engine and the storage array of a serial configuration memory. It observes every decoded 32-bit word write (address plus data, one cycle strobe) and recognises short fixed sequences of magic values written to fixed addresses. The matched sequences switch write protection on or off, choose the reset/enable polarity option, open or close a status readback window, request a whole-array erase, or close a special function. Ordinary word writes at aligned addresses are passed on to the array one cycle later unless protection is on.

The block owns the protection flag, the pending and active polarity flags and the status-window flag. A polarity change only becomes visible on the active output after a pulse on the reload input, standing in for a power cycle. While the status window is open, a read at word address 1 is steered to a composed configuration word instead of the array.

Top module: `spclCmdDecoder`

## Requirements
- R1: After reset protectOn, polPending, polActive and statusEn are 0, and arrayWrEn and eraseStb are low.
- R2: A write whose address has bits [1:0] equal to 00 and that is not consumed as a sequence step appears on arrayWrEn/arrayWrAddr/arrayWrData in the next cycle if protectOn was 0 at the write; a write with bits [1:0] nonzero is never forwarded.
- R3: The unlock pair (0xAAAAAAAA to address 0x55555, then 0x55555555 to 0x2AAAA) followed by 0x000000A0 to 0x55555 sets protectOn; while set, aligned writes are not forwarded.
- R4: protectOn clears only after an unlock pair plus 0x00000080 to 0x55555, immediately followed by a second unlock pair plus 0x00000020 to 0x55555; in that second sequence any other final value has no effect, and a lone 0x20 final is no command.
- R5: Unlock pair plus 0x000000F2 sets statusEn; while set, statusSel is 1 exactly when rdAddr equals 1, and statusWord has bits [31:24] all ones if protected or all zeros if not, bit 23 equal to polActive and bits [22:0] zero.
- R6: Unlock pair plus 0x00000000 to 0x55555 clears statusEn.
- R7: Unlock pair plus 0x000000FF sets polPending to 0 (reset active low), plus 0x0000FFFF sets it to 1; polActive takes polPending only at a reloadPulse.
- R8: Writing 0x555555 to 0x2AAAA, then 0xAAAAAA to 0x55555, then 0x555555 to 0x000B0 raises eraseStb for one cycle after the third write; that third write is not forwarded.
- R9: Any write that does not match the expected next step returns the decoder to idle with no command effect; the aborted sequence's later steps alone do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reloadPulse | input | 1 | Applies pending polarity to the active polarity |
| wrValid | input | 1 | Decoded word write strobe |
| wrAddr | input | ADDR_W | Write byte address |
| wrData | input | 32 | Write word |
| rdAddr | input | ADDR_W | Current read address |
| arrayWrEn | output | 1 | Forwarded array write strobe |
| arrayWrAddr | output | ADDR_W | Forwarded write address |
| arrayWrData | output | 32 | Forwarded write word |
| eraseStb | output | 1 | Whole-array erase request pulse |
| protectOn | output | 1 | Write protection flag |
| polPending | output | 1 | Polarity option awaiting reload |
| polActive | output | 1 | Polarity option in force |
| statusEn | output | 1 | Status readback window open |
| statusSel | output | 1 | Current read served by the status word |
| statusWord | output | 32 | Composed configuration word |

## Verification
On every cycle the assertions check that protection only moves in the cycle after a write, that no forwarded write escapes a set protection flag or carries an unaligned address, that erase and forward never coincide, that the erase strobe lasts one cycle, that the active polarity moves only after a reload, and that at most one command strobe fires at once. Whether each magic value selects the right command, that the disable really needs the doubled sequence, and that broken sequences leave no trace can only be shown by the bench, which sweeps every low-byte final value after the unlock pair against an arithmetic model and then runs the directed erase, abort and polarity scenarios.

// File: rtl/spclCmdPkg.sv
package spclCmdPkg;
  localparam int WORD_W = 32;

  localparam logic [WORD_W-1:0] KEY_FIRST   = 32'hAAAA_AAAA;
  localparam logic [WORD_W-1:0] KEY_SECOND  = 32'h5555_5555;
  localparam logic [WORD_W-1:0] OP_PROT_ON  = 32'h0000_00A0;
  localparam logic [WORD_W-1:0] OP_OFF_ARM  = 32'h0000_0080;
  localparam logic [WORD_W-1:0] OP_OFF_FIRE = 32'h0000_0020;
  localparam logic [WORD_W-1:0] OP_STATUS   = 32'h0000_00F2;
  localparam logic [WORD_W-1:0] OP_POL_LOW  = 32'h0000_00FF;
  localparam logic [WORD_W-1:0] OP_POL_HIGH = 32'h0000_FFFF;
  localparam logic [WORD_W-1:0] OP_EXIT     = 32'h0000_0000;
  localparam logic [WORD_W-1:0] WIPE_ODD    = 32'h0055_5555;
  localparam logic [WORD_W-1:0] WIPE_EVEN   = 32'h00AA_AAAA;

  localparam int unsigned LOC_CMD    = 32'h0005_5555;
  localparam int unsigned LOC_ALT    = 32'h0002_AAAA;
  localparam int unsigned LOC_WIPE   = 32'h0000_00B0;
  localparam int unsigned LOC_STATUS = 32'h0000_0001;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_KEY1,
    SQ_KEY2,
    SQ_WIPE1,
    SQ_WIPE2
  } seqState_t;

  typedef struct packed {
    logic fwdWrite;
    logic setProt;
    logic clrProt;
    logic setStatus;
    logic clrStatus;
    logic loadPol;
    logic polVal;
    logic wipe;
  } ctlStrobes_t;
endpackage

// File: rtl/spclSeqCtl.sv
module spclSeqCtl
  import spclCmdPkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  output ctlStrobes_t       stb
);
  localparam logic [ADDR_W-1:0] ADR_CMD  = ADDR_W'(LOC_CMD);
  localparam logic [ADDR_W-1:0] ADR_ALT  = ADDR_W'(LOC_ALT);
  localparam logic [ADDR_W-1:0] ADR_WIPE = ADDR_W'(LOC_WIPE);

  seqState_t state, nState;
  logic      armOff, nArm;
  logic      atCmd, atAlt, atWipe, aligned, consumed;

  assign atCmd   = (wrAddr == ADR_CMD);
  assign atAlt   = (wrAddr == ADR_ALT);
  assign atWipe  = (wrAddr == ADR_WIPE);
  assign aligned = (wrAddr[1:0] == 2'b00);

  always_comb begin
    stb      = '0;
    nState   = state;
    nArm     = armOff;
    consumed = 1'b0;
    if (wrValid) begin
      nState = SQ_IDLE;
      nArm   = 1'b0;
      case (state)
        SQ_IDLE: begin
          if (atCmd && wrData == KEY_FIRST) begin
            nState = SQ_KEY1;
            nArm   = armOff;
          end else if (!armOff && atAlt && wrData == WIPE_ODD) begin
            nState = SQ_WIPE1;
          end
        end
        SQ_KEY1: begin
          if (atAlt && wrData == KEY_SECOND) begin
            nState = SQ_KEY2;
            nArm   = armOff;
          end
        end
        SQ_KEY2: begin
          if (atCmd) begin
            if (armOff) begin
              stb.clrProt = (wrData == OP_OFF_FIRE);
            end else begin
              case (wrData)
                OP_PROT_ON:  stb.setProt = 1'b1;
                OP_OFF_ARM:  nArm = 1'b1;
                OP_STATUS:   stb.setStatus = 1'b1;
                OP_POL_LOW:  begin stb.loadPol = 1'b1; stb.polVal = 1'b0; end
                OP_POL_HIGH: begin stb.loadPol = 1'b1; stb.polVal = 1'b1; end
                OP_EXIT:     stb.clrStatus = 1'b1;
                default:     ;
              endcase
            end
          end
        end
        SQ_WIPE1: begin
          if (atCmd && wrData == WIPE_EVEN) nState = SQ_WIPE2;
        end
        SQ_WIPE2: begin
          if (atWipe && wrData == WIPE_ODD) begin
            stb.wipe = 1'b1;
            consumed = 1'b1;
          end
        end
        default: ;
      endcase
      stb.fwdWrite = aligned && !consumed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SQ_IDLE;
      armOff <= 1'b0;
    end else begin
      state  <= nState;
      armOff <= nArm;
    end
  end

  // R3 R4 R5 R6 R7 R8: a single write selects at most one command
  a_r9_one_command: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setProt, stb.clrProt, stb.setStatus, stb.clrStatus, stb.loadPol, stb.wipe}));

  // R4: the disable arm is only raised by the final step of an unlock sequence
  a_r4_arm_from_key2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armOff) |-> ($past(state) == SQ_KEY2 && $past(wrValid)));
endmodule

// File: rtl/spclCfgRegs.sv
module spclCfgRegs
  import spclCmdPkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reloadPulse,
  input  ctlStrobes_t       stb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              arrayWrEn,
  output logic [ADDR_W-1:0] arrayWrAddr,
  output logic [WORD_W-1:0] arrayWrData,
  output logic              eraseStb,
  output logic              protectOn,
  output logic              polPending,
  output logic              polActive,
  output logic              statusEn,
  output logic              statusSel,
  output logic [WORD_W-1:0] statusWord
);
  localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(LOC_STATUS);
  localparam int FLAG_BITS = 8;
  localparam int POL_BIT   = WORD_W - FLAG_BITS - 1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protectOn   <= 1'b0;
      statusEn    <= 1'b0;
      polPending  <= 1'b0;
      polActive   <= 1'b0;
      arrayWrEn   <= 1'b0;
      eraseStb    <= 1'b0;
      arrayWrAddr <= '0;
      arrayWrData <= '0;
    end else begin
      if (stb.setProt)        protectOn <= 1'b1;
      else if (stb.clrProt)   protectOn <= 1'b0;
      if (stb.setStatus)      statusEn  <= 1'b1;
      else if (stb.clrStatus) statusEn  <= 1'b0;
      if (stb.loadPol)        polPending <= stb.polVal;
      if (reloadPulse)        polActive  <= polPending;
      arrayWrEn <= stb.fwdWrite && !protectOn;
      eraseStb  <= stb.wipe;
      if (stb.fwdWrite) begin
        arrayWrAddr <= wrAddr;
        arrayWrData <= wrData;
      end
    end
  end

  assign statusSel  = statusEn && (rdAddr == ADR_STATUS);
  assign statusWord = {{FLAG_BITS{protectOn}}, polActive, {POL_BIT{1'b0}}};

  // R8: erase request is a single-cycle pulse
  a_r8_wipe_single: assert property (@(posedge clk) disable iff (!rstN)
    eraseStb |=> !eraseStb);

  // R7: the active polarity only moves on a reload pulse
  a_r7_active_on_reload: assert property (@(posedge clk) disable iff (!rstN)
    (polActive != $past(polActive)) |-> $past(reloadPulse));
endmodule

// File: rtl/spclCmdDecoder.sv
module spclCmdDecoder
  import spclCmdPkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reloadPulse,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              arrayWrEn,
  output logic [ADDR_W-1:0] arrayWrAddr,
  output logic [31:0]       arrayWrData,
  output logic              eraseStb,
  output logic              protectOn,
  output logic              polPending,
  output logic              polActive,
  output logic              statusEn,
  output logic              statusSel,
  output logic [31:0]       statusWord
);
  ctlStrobes_t stb;

  spclSeqCtl #(.ADDR_W(ADDR_W)) ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .stb(stb)
  );

  spclCfgRegs #(.ADDR_W(ADDR_W)) regs (
    .clk(clk), .rstN(rstN), .reloadPulse(reloadPulse), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .arrayWrEn(arrayWrEn), .arrayWrAddr(arrayWrAddr), .arrayWrData(arrayWrData),
    .eraseStb(eraseStb), .protectOn(protectOn), .polPending(polPending),
    .polActive(polActive), .statusEn(statusEn), .statusSel(statusSel),
    .statusWord(statusWord)
  );

  // R3 R4: protection changes only in the cycle after a write
  a_r3_prot_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (protectOn != $past(protectOn)) |-> $past(wrValid));

  // R2 R3: nothing is forwarded while protection was set
  a_r2_blocked_when_prot: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrEn |-> ($past(wrValid) && !$past(protectOn)));

  // R2: forwarded addresses are word aligned
  a_r2_fwd_aligned: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrEn |-> (arrayWrAddr[1:0] == 2'b00));

  // R8: the erase step is never also an array write
  a_r8_wipe_not_fwd: assert property (@(posedge clk) disable iff (!rstN)
    eraseStb |-> !arrayWrEn);
endmodule

// File: tb/spclCmdDecoder_test.sv
`timescale 1ns/1ps
module spclCmdDecoder_test;
  localparam int ADDR_W = 19;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reloadPulse = 1'b0;
  logic wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic arrayWrEn, eraseStb, protectOn, polPending, polActive, statusEn, statusSel;
  logic [ADDR_W-1:0] arrayWrAddr;
  logic [31:0] arrayWrData, statusWord;

  int nChecks = 0;
  int nFails = 0;
  logic lastFwd, lastErase;
  logic [ADDR_W-1:0] lastFwdAddr;
  logic [31:0] lastFwdData;
  logic mProt = 0, mStat = 0, mPend = 0, mAct = 0, mArm = 0;

  always #2.5 clk = ~clk;

  spclCmdDecoder #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .reloadPulse(reloadPulse), .wrValid(wrValid),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .arrayWrEn(arrayWrEn), .arrayWrAddr(arrayWrAddr), .arrayWrData(arrayWrData),
    .eraseStb(eraseStb), .protectOn(protectOn), .polPending(polPending),
    .polActive(polActive), .statusEn(statusEn), .statusSel(statusSel),
    .statusWord(statusWord)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    lastFwd = arrayWrEn; lastFwdAddr = arrayWrAddr;
    lastFwdData = arrayWrData; lastErase = eraseStb;
  endtask

  task automatic cmdSeq(input logic [31:0] v);
    wr(19'h55555, 32'hAAAAAAAA);
    wr(19'h2AAAA, 32'h55555555);
    wr(19'h55555, v);
    if (mArm) begin
      if (v == 32'h20) mProt = 1'b0;
      mArm = 1'b0;
    end else begin
      case (v)
        32'hA0:   mProt = 1'b1;
        32'h80:   mArm = 1'b1;
        32'hF2:   mStat = 1'b1;
        32'hFF:   mPend = 1'b0;
        32'hFFFF: mPend = 1'b1;
        32'h00:   mStat = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic chkFlags(input string tag);
    chk({tag, " prot"}, 32'(protectOn), 32'(mProt));
    chk({tag, " stat"}, 32'(statusEn), 32'(mStat));
    chk({tag, " pend"}, 32'(polPending), 32'(mPend));
    chk({tag, " act"}, 32'(polActive), 32'(mAct));
  endtask

  task automatic reload();
    @(negedge clk); reloadPulse = 1'b1;
    @(negedge clk); reloadPulse = 1'b0;
    mAct = mPend;
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chkFlags("R1 reset");
    chk("R1 wrEn", 32'(arrayWrEn), 0);
    chk("R1 erase", 32'(eraseStb), 0);

    // R2 forwarding
    wr(19'h00010, 32'h12345678);
    chk("R2 fwd en", 32'(lastFwd), 1);
    chk("R2 fwd addr", 32'(lastFwdAddr), 32'h10);
    chk("R2 fwd data", lastFwdData, 32'h12345678);
    for (int lo = 1; lo < 4; lo++) begin
      wr(19'(32'h00020 + lo), 32'hCAFE0000);
      chk("R2 unaligned blocked", 32'(lastFwd), 0);
    end

    // Sweep of every low-byte final value after the unlock pair (R3 R5 R6 R7 R9)
    for (int v = 0; v < 256; v++) begin
      cmdSeq(32'(v));
      chkFlags("sweep R3 R6 R7 R9");
      wr(19'(v * 4), 32'(v) ^ 32'h5A5A0000);
      mArm = 1'b0;
      chk("sweep R2 R3 fwd", 32'(lastFwd), 32'(!mProt));
    end

    // R4 lone fire value and doubled disable
    cmdSeq(32'h20);
    chk("R4 lone 0x20", 32'(protectOn), 32'(mProt));
    chk("R4 still on", 32'(protectOn), 1);
    cmdSeq(32'h80);
    cmdSeq(32'hA0);
    chk("R4 wrong second final", 32'(protectOn), 1);
    cmdSeq(32'h80);
    wr(19'h00100, 32'h1);
    mArm = 1'b0;
    cmdSeq(32'h20);
    chk("R9 broken between halves", 32'(protectOn), 1);
    cmdSeq(32'h80);
    cmdSeq(32'h20);
    chk("R4 doubled disable", 32'(protectOn), 0);
    wr(19'h00200, 32'hBEEF);
    chk("R4 fwd after disable", 32'(lastFwd), 1);

    // R5 status window
    cmdSeq(32'hF2);
    cmdSeq(32'hA0);
    rdAddr = 19'h1; #1;
    chk("R5 sel at 1", 32'(statusSel), 1);
    chk("R5 word prot", statusWord, {8'hFF, mAct, 23'h0});
    rdAddr = 19'h5; #1;
    chk("R5 sel elsewhere", 32'(statusSel), 0);
    rdAddr = 19'h0; #1;
    chk("R5 sel at 0", 32'(statusSel), 0);

    // R7 polarity needs reload
    cmdSeq(32'hFFFF);
    chkFlags("R7 pending high");
    chk("R7 active held", 32'(polActive), 0);
    reload();
    chkFlags("R7 after reload");
    rdAddr = 19'h1; #1;
    chk("R5 R7 word bit23", statusWord, {8'hFF, 1'b1, 23'h0});
    cmdSeq(32'hFF);
    chk("R7 pending low", 32'(polPending), 0);
    chk("R7 active kept", 32'(polActive), 1);
    reload();
    chkFlags("R7 reload low");

    // R6 exit closes window
    cmdSeq(32'h00);
    #1;
    chk("R6 exit clears", 32'(statusEn), 0);
    chk("R6 sel gone", 32'(statusSel), 0);

    // R9 broken unlock
    wr(19'h55555, 32'hAAAAAAAA);
    wr(19'h55555, 32'h55555555);
    wr(19'h55555, 32'hF2);
    chk("R9 broken unlock", 32'(statusEn), 0);

    // R8 erase, with protection off
    cmdSeq(32'h80);
    cmdSeq(32'h20);
    wr(19'h2AAAA, 32'h00555555);
    chk("R8 no early erase", 32'(lastErase), 0);
    wr(19'h55555, 32'h00AAAAAA);
    wr(19'h000B0, 32'h00555555);
    chk("R8 erase pulse", 32'(lastErase), 1);
    chk("R8 step not fwd", 32'(lastFwd), 0);
    @(negedge clk);
    chk("R8 pulse ends", 32'(eraseStb), 0);

    // R9 broken erase: final step alone is an ordinary write
    wr(19'h2AAAA, 32'h00555555);
    wr(19'h2AAAA, 32'h00AAAAAA);
    wr(19'h000B0, 32'h00555555);
    chk("R9 broken erase", 32'(lastErase), 0);
    chk("R9 broken erase fwd", 32'(lastFwd), 1);
    chkFlags("R9 final flags");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule